// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Controller Pair

This block joins two eight-line interrupt controller units into one sixteen-line interrupt system. Request lines 0 to 7 go to the primary unit and lines 8 to 15 go to the secondary unit. Whenever the secondary unit's resolver has a valid winner, that request is latched on line 2 of the primary unit as a request edge. The single interrupt output is high exactly while the primary unit's resolver has a valid winner.

A processor acknowledge strobe walks the cascade: the primary winner is acknowledged first, and if that winner is line 2, the secondary winner is acknowledged too. The resulting 8-bit vector appears one cycle later, together with a one-cycle valid pulse. The vector is the upper five bits of the chosen unit's programmed base, followed by the line index. An acknowledge that finds no winner produces line 7 of the unit concerned as a spurious vector.

Software reaches the units through a byte-wide I/O bus with a small address map. Each unit has a command port and a data port. Each unit also has a trigger-mode register that selects edge or level detection per line.

Top module: `pic_pair`

## Requirements
- R1: After reset, the interrupt output and the vector-valid output are low. Reads of the primary data port (0x21) and the primary command port (0x20) return 0.
- R2: In edge mode, a request line going from low to high latches a request. The interrupt output is high exactly while the primary unit has an unmasked request whose priority is above every line in service.
- R3: If an acknowledge strobe finds a primary winner other than line 2, the vector is the primary base with the line number in bits 2:0, and vector-valid is high in the cycle after the strobe. The base is set by the second initialisation write.
- R4: A secondary winner sets primary line 2. Acknowledging primary line 2 also acknowledges the secondary winner, and the vector is the secondary base plus the secondary line.
- R5: If an acknowledge finds no primary winner, the vector is the primary base plus 7.
- R6: If the primary winner is line 2 but the secondary unit has no winner, the vector is the secondary base plus 7.
- R7: Lower line numbers have higher priority. An in-service line blocks its own line and every lower-priority line until it is cleared.
- R8: A command-port write of 0x20 clears the highest-priority in-service bit. Command 0x0B selects the in-service register for command-port reads, and 0x0A selects the request register.
- R9: Data-port writes in normal mode set the mask register, which reads back from the data port. A masked line never raises the interrupt output, and unmasking a pending line raises it.
- R10: Addresses 0x4D0 and 0x4D1 hold the primary and secondary trigger-mode registers, with writable bits 0xF8 and 0xDE. A set bit makes the line level-sensitive, so its request disappears when the line drops.
- R11: A command write of 0x0C arms a poll. The next read of that unit returns the winner index, or 7 if there is none, and clears the winner's request and in-service bits. A secondary poll that finds a winner also clears bit 2 of the primary unit's request and in-service registers.
- R12: Writes to unmapped addresses change nothing, and reads from unmapped addresses return 0.
- R13: A command write with bit 4 set starts initialisation. The sequence is: base write, cascade write, then a mode write if bit 0 of the command was set. Mode bit 1 selects auto end-of-interrupt, in which an acknowledged line leaves no in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 16 | Request lines; 0-7 primary, 8-15 secondary (line 2 shares the cascade) |
| intr_o | output | 1 | Interrupt request to the processor |
| inta_i | input | 1 | Acknowledge strobe, one cycle per acknowledge |
| vec_o | output | 8 | Vector of the last acknowledge |
| vec_valid_o | output | 1 | High in the cycle after an acknowledge strobe |
| io_addr_i | input | ADDR_W | Byte I/O address |
| io_wdata_i | input | 8 | Write data |
| io_wr_i | input | 1 | Write strobe |
| io_rd_i | input | 1 | Read strobe |
| io_rdata_o | output | 8 | Read data, registered, valid the cycle after the strobe |

## Verification
The hardest situation to reach from the ports is a spurious secondary acknowledge. Primary line 2 has to be latched while the secondary unit no longer has a winner. The stimulus raises a secondary line and waits two cycles for the cascade edge to land on primary line 2. It then masks that secondary line through the secondary data port, or, in a second variant, makes the line level-sensitive and drops it. In both cases the acknowledge must return the secondary base plus 7. Unmasking afterwards must bring back the still-pending request.

// File: rtl/pic_pkg.sv
`timescale 1ns/1ps
package pic_pkg;
   localparam int LINES = 8;
   localparam int IDX_W = $clog2(LINES);
   localparam int BASE_W = 8 - IDX_W;
   localparam logic [IDX_W-1:0] CASC_IDX = IDX_W'(2);
   localparam logic [IDX_W-1:0] SPUR_IDX = {IDX_W{1'b1}};
   localparam logic [IDX_W:0]   NO_PRIO = (IDX_W+1)'(LINES);

   typedef enum logic [1:0] {ST_RUN, ST_BASE, ST_CASC, ST_MODE} init_st_t;
   typedef enum logic [2:0] {SRC_NONE, SRC_MCTL, SRC_SCTL, SRC_MTRIG, SRC_STRIG} rd_src_t;

   // rank of the best set bit, counting from the rotation point; NO_PRIO when empty
   function automatic logic [IDX_W:0] best_prio(input logic [LINES-1:0] m,
                                                input logic [IDX_W-1:0] rot);
      logic [IDX_W:0]   p;
      logic [IDX_W-1:0] k;
      p = NO_PRIO;
      for (int i = LINES - 1; i >= 0; i--) begin
         k = IDX_W'(i) + rot;
         if (m[k]) p = (IDX_W+1)'(i);
      end
      return p;
   endfunction
endpackage

// File: rtl/pic_addr_dec.sv
`timescale 1ns/1ps
module pic_addr_dec
   import pic_pkg::*;
#(
   parameter int                ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] M_PORT    = 'h20,
   parameter logic [ADDR_W-1:0] S_PORT    = 'hA0,
   parameter logic [ADDR_W-1:0] TRIG_PORT = 'h4D0
)(
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic              rd_i,
   output logic              m_cmd_wr_o,
   output logic              m_dat_wr_o,
   output logic              s_cmd_wr_o,
   output logic              s_dat_wr_o,
   output logic              mt_wr_o,
   output logic              st_wr_o,
   output logic              m_rd_o,
   output logic              s_rd_o,
   output rd_src_t           src_o
);
   logic hit_m, hit_s, hit_t, odd;

   always_comb begin
      odd   = addr_i[0];
      hit_m = addr_i[ADDR_W-1:1] == M_PORT[ADDR_W-1:1];
      hit_s = addr_i[ADDR_W-1:1] == S_PORT[ADDR_W-1:1];
      hit_t = addr_i[ADDR_W-1:1] == TRIG_PORT[ADDR_W-1:1];
      if (hit_m)      src_o = SRC_MCTL;
      else if (hit_s) src_o = SRC_SCTL;
      else if (hit_t) src_o = odd ? SRC_STRIG : SRC_MTRIG;
      else            src_o = SRC_NONE;
      m_cmd_wr_o = wr_i && src_o == SRC_MCTL && !odd;
      m_dat_wr_o = wr_i && src_o == SRC_MCTL && odd;
      s_cmd_wr_o = wr_i && src_o == SRC_SCTL && !odd;
      s_dat_wr_o = wr_i && src_o == SRC_SCTL && odd;
      mt_wr_o    = wr_i && src_o == SRC_MTRIG;
      st_wr_o    = wr_i && src_o == SRC_STRIG;
      m_rd_o     = rd_i && src_o == SRC_MCTL;
      s_rd_o     = rd_i && src_o == SRC_SCTL;
   end
endmodule

// File: rtl/pic_unit.sv
`timescale 1ns/1ps
module pic_unit
   import pic_pkg::*;
#(
   parameter bit               IS_MASTER = 1'b1,
   parameter logic [LINES-1:0] TRIG_MASK = 8'hF8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINES-1:0]  line_i,
   input  logic              casc_set_i,
   input  logic              casc_clr_i,
   input  logic              cmd_wr_i,
   input  logic              dat_wr_i,
   input  logic              trig_wr_i,
   input  logic              rd_i,
   input  logic              rd_sel_i,
   input  logic [7:0]        wdata_i,
   input  logic              ack_i,
   output logic [7:0]        rdata_o,
   output logic [LINES-1:0]  trig_o,
   output logic              win_o,
   output logic [IDX_W-1:0]  idx_o,
   output logic [BASE_W-1:0] base_o,
   output logic              poll_hit_o
);
   logic [LINES-1:0]  irr, isr, imr, trig, last, irr_n, isr_n, isr_vis;
   logic [IDX_W-1:0]  rot, win_idx, eoi_idx;
   logic [IDX_W:0]    req_p, cur_p, eoi_p;
   logic [BASE_W-1:0] base;
   init_st_t          st;
   logic need4, aeoi, rot_aeoi, sfnm, poll, rsel, win, poll_hit;
   logic is_init, is_ocw3, is_ocw2;

   // priority resolution
   always_comb begin
      isr_vis = isr;
      if (IS_MASTER && sfnm) isr_vis[CASC_IDX] = 1'b0;
      req_p   = best_prio(irr & ~imr, rot);
      cur_p   = best_prio(isr_vis, rot);
      eoi_p   = best_prio(isr, rot);
      win     = req_p < cur_p;
      win_idx = req_p[IDX_W-1:0] + rot;
      eoi_idx = eoi_p[IDX_W-1:0] + rot;
      is_init = cmd_wr_i && wdata_i[4];
      is_ocw3 = cmd_wr_i && !wdata_i[4] && wdata_i[3];
      is_ocw2 = cmd_wr_i && !wdata_i[4] && !wdata_i[3];
      poll_hit = rd_i && poll && win;
   end

   // next request / in-service state
   always_comb begin
      irr_n = irr;
      isr_n = isr;
      for (int b = 0; b < LINES; b++) begin
         if (trig[b])                    irr_n[b] = line_i[b];
         else if (line_i[b] && !last[b]) irr_n[b] = 1'b1;
      end
      if (casc_set_i) irr_n[CASC_IDX] = 1'b1;
      if (ack_i && win) begin
         if (!aeoi)          isr_n[win_idx] = 1'b1;
         if (!trig[win_idx]) irr_n[win_idx] = 1'b0;
      end
      if (poll_hit) begin
         irr_n[win_idx] = 1'b0;
         isr_n[win_idx] = 1'b0;
      end
      if (casc_clr_i) begin
         irr_n[CASC_IDX] = 1'b0;
         isr_n[CASC_IDX] = 1'b0;
      end
      if (is_init) begin
         irr_n = irr_n & trig;
         isr_n = '0;
      end else if (is_ocw2) begin
         case (wdata_i[7:5])
            3'd1, 3'd5: if (eoi_p != NO_PRIO) isr_n[eoi_idx] = 1'b0;
            3'd3, 3'd7: isr_n[wdata_i[IDX_W-1:0]] = 1'b0;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irr <= '0; isr <= '0; imr <= '0; trig <= '0; last <= '0;
         rot <= '0; base <= '0; st <= ST_RUN;
         need4 <= 1'b0; aeoi <= 1'b0; rot_aeoi <= 1'b0; sfnm <= 1'b0;
         poll <= 1'b0; rsel <= 1'b0;
      end else begin
         irr  <= irr_n;
         isr  <= isr_n;
         last <= line_i;
         if (ack_i && win && aeoi && rot_aeoi) rot <= win_idx + 1'b1;
         if (rd_i && poll) poll <= 1'b0;
         if (trig_wr_i) trig <= wdata_i & TRIG_MASK;
         if (is_init) begin
            imr   <= '0;
            last  <= '0;
            rot   <= '0;
            rsel  <= 1'b0;
            poll  <= 1'b0;
            need4 <= wdata_i[0];
            if (!wdata_i[0]) begin
               sfnm <= 1'b0;
               aeoi <= 1'b0;
            end
            st <= ST_BASE;
         end else if (is_ocw3) begin
            if (wdata_i[2]) poll <= 1'b1;
            if (wdata_i[1]) rsel <= wdata_i[0];
         end else if (is_ocw2) begin
            case (wdata_i[7:5])
               3'd0, 3'd4: rot_aeoi <= wdata_i[7];
               3'd5:       if (eoi_p != NO_PRIO) rot <= eoi_idx + 1'b1;
               3'd6, 3'd7: rot <= wdata_i[IDX_W-1:0] + 1'b1;
               default: ;
            endcase
         end
         if (dat_wr_i) begin
            case (st)
               ST_RUN:  imr <= wdata_i;
               ST_BASE: begin
                  base <= wdata_i[7:IDX_W];
                  st   <= ST_CASC;
               end
               ST_CASC: st <= need4 ? ST_MODE : ST_RUN;
               ST_MODE: begin
                  sfnm <= wdata_i[4];
                  aeoi <= wdata_i[1];
                  st   <= ST_RUN;
               end
               default: st <= ST_RUN;
            endcase
         end
      end
   end

   always_comb begin
      if (poll)          rdata_o = win ? 8'(win_idx) : 8'(SPUR_IDX);
      else if (rd_sel_i) rdata_o = imr;
      else               rdata_o = rsel ? isr : irr;
   end

   assign trig_o     = trig;
   assign win_o      = win;
   assign idx_o      = win_idx;
   assign base_o     = base;
   assign poll_hit_o = poll_hit;

   // an accepted acknowledge leaves the winner in service (R7)
   p_ack_isr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && win && !aeoi && !cmd_wr_i && !casc_clr_i && !poll_hit) |=> isr[$past(win_idx)]);

   // a poll is consumed by exactly one read (R11)
   p_poll_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && poll && !cmd_wr_i) |=> !poll);

   // a level-sensitive line that was low leaves no request (R10)
   for (genvar k = 0; k < LINES; k++) begin : g_lvl
      if (TRIG_MASK[k]) begin : g_chk
         p_level_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(trig[k]) && !$past(line_i[k])) |-> !irr[k]);
      end
   end
endmodule

// File: rtl/pic_pair.sv
`timescale 1ns/1ps
module pic_pair
   import pic_pkg::*;
#(
   parameter int                ADDR_W      = 16,
   parameter logic [ADDR_W-1:0] M_PORT      = 'h20,
   parameter logic [ADDR_W-1:0] S_PORT      = 'hA0,
   parameter logic [ADDR_W-1:0] TRIG_PORT   = 'h4D0,
   parameter logic [7:0]        M_TRIG_MASK = 8'hF8,
   parameter logic [7:0]        S_TRIG_MASK = 8'hDE
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       irq_i,
   output logic              intr_o,
   input  logic              inta_i,
   output logic [7:0]        vec_o,
   output logic              vec_valid_o,
   input  logic [ADDR_W-1:0] io_addr_i,
   input  logic [7:0]        io_wdata_i,
   input  logic              io_wr_i,
   input  logic              io_rd_i,
   output logic [7:0]        io_rdata_o
);
   if (ADDR_W < 11) begin : g_bad_width
      $error("pic_pair: ADDR_W too small for the trigger-mode port");
   end
   if (M_PORT[0] || S_PORT[0] || TRIG_PORT[0]) begin : g_bad_align
      $error("pic_pair: port pairs must start on an even address");
   end
   if (M_PORT[ADDR_W-1:1] == S_PORT[ADDR_W-1:1]) begin : g_bad_overlap
      $error("pic_pair: primary and secondary ports overlap");
   end
   if (M_TRIG_MASK[CASC_IDX]) begin : g_bad_casc
      $error("pic_pair: cascade line must stay edge-triggered");
   end

   logic m_cmd_wr, m_dat_wr, s_cmd_wr, s_dat_wr, mt_wr, st_wr, m_rd, s_rd;
   rd_src_t src;
   logic [7:0]        m_rdata, s_rdata, vec_d, vec_q;
   logic [LINES-1:0]  m_trig, s_trig;
   logic              m_win, s_win, m_poll_hit, s_poll_hit, s_ack, vld_q;
   logic [IDX_W-1:0]  m_idx, s_idx;
   logic [BASE_W-1:0] m_base, s_base;

   pic_addr_dec #(.ADDR_W(ADDR_W), .M_PORT(M_PORT), .S_PORT(S_PORT), .TRIG_PORT(TRIG_PORT)) u_dec (
      .addr_i(io_addr_i), .wr_i(io_wr_i), .rd_i(io_rd_i),
      .m_cmd_wr_o(m_cmd_wr), .m_dat_wr_o(m_dat_wr), .s_cmd_wr_o(s_cmd_wr), .s_dat_wr_o(s_dat_wr),
      .mt_wr_o(mt_wr), .st_wr_o(st_wr), .m_rd_o(m_rd), .s_rd_o(s_rd), .src_o(src));

   assign s_ack = inta_i && m_win && (m_idx == CASC_IDX);

   pic_unit #(.IS_MASTER(1'b1), .TRIG_MASK(M_TRIG_MASK)) u_prim (
      .clk(clk), .rst_n(rst_n), .line_i(irq_i[7:0]),
      .casc_set_i(s_win), .casc_clr_i(s_poll_hit),
      .cmd_wr_i(m_cmd_wr), .dat_wr_i(m_dat_wr), .trig_wr_i(mt_wr),
      .rd_i(m_rd), .rd_sel_i(io_addr_i[0]), .wdata_i(io_wdata_i), .ack_i(inta_i),
      .rdata_o(m_rdata), .trig_o(m_trig), .win_o(m_win), .idx_o(m_idx),
      .base_o(m_base), .poll_hit_o(m_poll_hit));

   pic_unit #(.IS_MASTER(1'b0), .TRIG_MASK(S_TRIG_MASK)) u_sec (
      .clk(clk), .rst_n(rst_n), .line_i(irq_i[15:8]),
      .casc_set_i(1'b0), .casc_clr_i(1'b0),
      .cmd_wr_i(s_cmd_wr), .dat_wr_i(s_dat_wr), .trig_wr_i(st_wr),
      .rd_i(s_rd), .rd_sel_i(io_addr_i[0]), .wdata_i(io_wdata_i), .ack_i(s_ack),
      .rdata_o(s_rdata), .trig_o(s_trig), .win_o(s_win), .idx_o(s_idx),
      .base_o(s_base), .poll_hit_o(s_poll_hit));

   always_comb begin
      if (!m_win)                 vec_d = {m_base, SPUR_IDX};
      else if (m_idx == CASC_IDX) vec_d = {s_base, s_win ? s_idx : SPUR_IDX};
      else                        vec_d = {m_base, m_idx};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vec_q      <= '0;
         vld_q      <= 1'b0;
         io_rdata_o <= '0;
      end else begin
         vld_q <= inta_i;
         if (inta_i) vec_q <= vec_d;
         if (io_rd_i) begin
            case (src)
               SRC_MCTL:  io_rdata_o <= m_rdata;
               SRC_SCTL:  io_rdata_o <= s_rdata;
               SRC_MTRIG: io_rdata_o <= m_trig;
               SRC_STRIG: io_rdata_o <= s_trig;
               default:   io_rdata_o <= '0;
            endcase
         end
      end
   end

   assign intr_o      = m_win;
   assign vec_o       = vec_q;
   assign vec_valid_o = vld_q;

   // primary winner other than the cascade line gives primary base + line (R3)
   p_vec_master_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_valid_o && $past(m_win) && $past(m_idx) != CASC_IDX)
         |-> vec_o == {$past(m_base), $past(m_idx)});

   // no primary winner gives primary base + 7 (R5)
   p_spur_master_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_valid_o && !$past(m_win)) |-> vec_o == {$past(m_base), SPUR_IDX});

   // cascade line without a secondary winner gives secondary base + 7 (R6)
   p_spur_slave_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_valid_o && $past(m_win) && $past(m_idx) == CASC_IDX && !$past(s_win))
         |-> vec_o == {$past(s_base), SPUR_IDX});

   // a poll read that hits returns a bare line index (R11)
   p_poll_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (m_poll_hit || s_poll_hit) |=> io_rdata_o[7:IDX_W] == '0);

   // unmapped reads return zero (R12)
   p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd_i && src == SRC_NONE) |=> io_rdata_o == 8'h00);
endmodule

// File: tb/pic_pair_tb_top.sv
`timescale 1ns/1ps
module pic_pair_tb_top;
   localparam time PERIOD = 20ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] irq = '0;
   logic        intr, inta = 1'b0, vec_valid;
   logic [7:0]  vec;
   logic [15:0] addr = '0;
   logic [7:0]  wdata = '0, rdata;
   logic        wr = 1'b0, rd = 1'b0;

   int    n_chk = 0;
   int    n_fail = 0;
   bit    reported = 1'b0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #(PERIOD/2) clk = ~clk;

   pic_pair dut_i (
      .clk(clk), .rst_n(rst_n), .irq_i(irq), .intr_o(intr), .inta_i(inta),
      .vec_o(vec), .vec_valid_o(vec_valid), .io_addr_i(addr), .io_wdata_i(wdata),
      .io_wr_i(wr), .io_rd_i(rd), .io_rdata_o(rdata));

   task automatic check(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic io_write(logic [15:0] a, logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic io_read(logic [15:0] a, logic [7:0] exp, string tag);
      @(negedge clk);
      addr = a; rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
      check(tag, rdata, exp);
   endtask

   // driver side of the scoreboard: push, then strobe
   task automatic ack(logic [7:0] exp, string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      inta = 1'b1;
      @(negedge clk);
      inta = 1'b0;
   endtask

   task automatic set_irq(int n, logic v);
      @(negedge clk);
      irq[n] = v;
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      end
   endtask

   // monitor side of the scoreboard
   always @(negedge clk) begin
      if (rst_n && vec_valid) begin
         n_chk++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R3: unexpected vector actual 0x%0h expected none", vec);
         end else begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            if (vec !== e) begin
               n_fail++;
               $display("FAIL %s: vector actual 0x%0h expected 0x%0h", t, vec, e);
            end
         end
      end
   end

   initial begin
      #(PERIOD * 150000);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      report();
      $finish;
   end

   initial begin
      tick(4);
      rst_n = 1'b1;
      // R1 reset state
      check("R1 intr", intr, 0);
      check("R1 vec_valid", vec_valid, 0);
      io_read(16'h21, 8'h00, "R1 mask");
      io_read(16'h20, 8'h00, "R1 request");

      // R13 initialisation: primary base 0x20, secondary base 0x28
      io_write(16'h20, 8'h11); io_write(16'h21, 8'h20); io_write(16'h21, 8'h04); io_write(16'h21, 8'h01);
      io_write(16'hA0, 8'h11); io_write(16'hA1, 8'h28); io_write(16'hA1, 8'h02); io_write(16'hA1, 8'h01);

      // R5 spurious primary
      ack(8'h27, "R5 spurious primary");

      // R2, R3 edge request on line 5
      set_irq(5, 1'b1); tick(3);
      check("R2 intr raised", intr, 1);
      ack(8'h25, "R3 line5 vector");
      check("R2 intr after ack", intr, 0);

      // R7 priority and in-service blocking
      @(negedge clk); irq[3] = 1'b1; irq[6] = 1'b1;
      tick(3);
      check("R7 line3 beats isr5", intr, 1);
      ack(8'h23, "R7 line3 vector");
      check("R7 line6 blocked", intr, 0);
      io_write(16'h20, 8'h20);
      check("R8 eoi clears 3 only", intr, 0);
      io_write(16'h20, 8'h20);
      check("R8 eoi clears 5", intr, 1);
      ack(8'h26, "R7 line6 vector");
      io_write(16'h20, 8'h20);
      check("R7 idle", intr, 0);
      @(negedge clk); irq[3] = 1'b0; irq[5] = 1'b0; irq[6] = 1'b0;

      // R4 cascade through line 2
      set_irq(12, 1'b1); tick(3);
      check("R4 intr via cascade", intr, 1);
      ack(8'h2C, "R4 secondary vector");
      io_write(16'hA0, 8'h20); io_write(16'h20, 8'h20);
      check("R4 idle", intr, 0);
      set_irq(12, 1'b0);

      // R6 spurious secondary by masking after the cascade latched
      set_irq(9, 1'b1); tick(3);
      io_write(16'hA1, 8'h02);
      check("R6 line2 still latched", intr, 1);
      ack(8'h2F, "R6 spurious secondary");
      io_write(16'h20, 8'h20);
      check("R6 masked quiet", intr, 0);
      io_write(16'hA1, 8'h00); tick(2);
      check("R9 unmask restores", intr, 1);
      ack(8'h29, "R4 line9 vector");
      io_write(16'hA0, 8'h20); io_write(16'h20, 8'h20);
      set_irq(9, 1'b0);
      check("R6 idle", intr, 0);

      // R9 mask register
      io_write(16'h21, 8'h02);
      io_read(16'h21, 8'h02, "R9 mask readback");
      set_irq(1, 1'b1); tick(3);
      check("R9 masked line", intr, 0);
      io_write(16'h21, 8'h00);
      check("R9 unmasked line", intr, 1);
      ack(8'h21, "R9 line1 vector");
      io_write(16'h20, 8'h20);
      set_irq(1, 1'b0);

      // R10 trigger-mode registers and level withdrawal
      io_write(16'h4D1, 8'hFF);
      io_read(16'h4D1, 8'hDE, "R10 secondary trigger mask");
      io_write(16'h4D0, 8'hFF);
      io_read(16'h4D0, 8'hF8, "R10 primary trigger mask");
      io_write(16'h4D0, 8'h00);
      set_irq(11, 1'b1); tick(3);
      check("R10 level request", intr, 1);
      set_irq(11, 1'b0); tick(3);
      ack(8'h2F, "R10 level withdrawn");
      io_write(16'h20, 8'h20);
      check("R10 idle", intr, 0);
      io_write(16'h4D1, 8'h00);

      // R11 poll on secondary and primary
      set_irq(13, 1'b1); tick(3);
      io_write(16'hA0, 8'h0C);
      io_read(16'hA0, 8'h05, "R11 secondary poll");
      tick(2);
      check("R11 cascade cleared", intr, 0);
      io_write(16'h20, 8'h0C);
      io_read(16'h20, 8'h07, "R11 empty poll");
      set_irq(13, 1'b0);

      // R8 register select
      set_irq(4, 1'b1); tick(2);
      ack(8'h24, "R3 line4 vector");
      io_write(16'h20, 8'h0B);
      io_read(16'h20, 8'h10, "R8 in-service read");
      io_write(16'h20, 8'h20);
      io_read(16'h20, 8'h00, "R8 in-service after eoi");
      io_write(16'h20, 8'h0A);
      set_irq(4, 1'b0);
      io_read(16'h20, 8'h00, "R8 request read");

      // R12 unmapped addresses
      io_write(16'h22, 8'hFF);
      io_read(16'h21, 8'h00, "R12 write ignored");
      io_read(16'h22, 8'h00, "R12 read zero");
      io_read(16'h4D2, 8'h00, "R12 read zero high");

      // R13 re-initialise with new base and auto end-of-interrupt
      io_write(16'h20, 8'h11); io_write(16'h21, 8'h40); io_write(16'h21, 8'h04); io_write(16'h21, 8'h03);
      set_irq(6, 1'b1); tick(2);
      ack(8'h46, "R13 new base");
      set_irq(7, 1'b1); tick(2);
      check("R13 auto eoi frees line7", intr, 1);
      ack(8'h47, "R13 line7 vector");
      check("R13 idle", intr, 0);
      io_write(16'h20, 8'h0B);
      io_read(16'h20, 8'h00, "R13 no in-service");

      tick(3);
      check("R3 scoreboard drained", exp_q.size(), 0);
      report();
      $finish;
   end
endmodule